// File: doc/BRIEF.md
# Modem Clock Source and Clock-Output Configurator

This block sits at the root of a low-power FSK modem's clocking. Three static strap inputs (a crystal-enable and two configuration bits) choose where the modem's reference clock comes from: a 3.6864 MHz crystal, an external CMOS clock at 3.6864 MHz or 1.2288 MHz, or the on-chip 1.2288 MHz oscillator. The same code decides whether a clock is driven out to the board, and at which division of the reference. The oscillator circuits themselves are outside the block. They are modelled as the single reference clock input, whose frequency is implied by the code.

From the reference the block derives a one-cycle core tick at the 1.2288 MHz modem rate. The reference is divided by three when it runs at 3.6864 MHz and passed through when it runs at 1.2288 MHz. The active-low reset pin doubles as a power-down control. While it is low, every output is quiet and the strap pins are sampled. The code seen at the first rising reference edge after release is frozen until the next reset.

Top module: `mdm_clkcfg`

## Requirements
- R1: While rst_n is low, pwr_down is 1 and core_tick, clkout_en and clkout are 0. pwr_down falls at the first rising ref_clk edge after rst_n rises (edge E0).
- R2: The code {xtal_en, cfg1, cfg0} is captured at E0. Changes on those pins after E0 have no effect on src_sel, core_tick, clkout_en or clkout until the next reset.
- R3: src_sel reads 0 (crystal) when xtal_en=0. It reads 1 (external clock) for codes 100 and 101, and 2 (internal oscillator) for codes 110 and 111.
- R4: clkout_en is 1 out of power-down exactly for codes 001, 010, 011 and 111. For every other code, clkout stays 0.
- R5: core_tick is a one-cycle pulse every third ref_clk cycle for codes 000, 001, 010, 011 and 100. It is 1 in every cycle for codes 101, 110 and 111. For the n-th cycle after E0 (n ≥ 1), the tick is high when (n−1) mod divisor is 0.
- R6: For codes 001 and 111, clkout follows ref_clk from the cycle after E0 onward. It is high in the high phase and low in the low phase.
- R7: For code 010, clkout divides by two with 50% duty. It is high for the whole n-th cycle after E0 when (n−1) mod 2 is 0.
- R8: For code 011, clkout divides by three. It is high for one whole cycle of every three, in the n-th cycle after E0 when (n−1) mod 3 is 0.
- R9: Driving rst_n low while running forces pwr_down to 1 and core_tick and clkout to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Selected reference clock (model of the active oscillator) |
| rst_n | input | 1 | Active-low reset; low holds power-down |
| xtal_en | input | 1 | Strap: 0 selects the crystal source |
| cfg0 | input | 1 | Strap: configuration bit 0 |
| cfg1 | input | 1 | Strap: configuration bit 1 |
| src_sel | output | 2 | Selected source: 0 crystal, 1 external, 2 internal |
| clkout_en | output | 1 | Board clock output is active |
| clkout | output | 1 | Board clock output, low when not enabled |
| core_tick | output | 1 | One-cycle pulse at the 1.2288 MHz modem rate |
| pwr_down | output | 1 | Power-down state flag |

## Verification
pwr_down, src_sel and clkout_en settle one edge after reset release (E0). core_tick and the divided clkout first go high in the cycle after the edge following E0. The ÷1 clkout gains its first high phase in that same cycle, because its gate opens on the falling edge after E0. The bench releases reset in a low phase, counts edges from E0 and samples every cycle a quarter period after the rising edge and again in the low phase. Expected values come from a modulo of that edge count. Reset entry is checked one nanosecond after rst_n falls, well before any edge.

// File: rtl/mdm_clkcfg_pkg.sv
package mdm_clkcfg_pkg;

  localparam int DIV_W  = 2;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_INT  = 2'd2
  } src_t;

  typedef struct packed {
    src_t             src;
    logic             co_en;
    logic [DIV_W-1:0] co_div;
    logic [DIV_W-1:0] tick_div;
  } cfg_dec_t;

  // code = {xtal_en, cfg1, cfg0}
  function automatic cfg_dec_t decode_code(input logic [CODE_W-1:0] code);
    cfg_dec_t d;
    d.src      = SRC_XTAL;
    d.co_en    = 1'b0;
    d.co_div   = '0;
    d.tick_div = DIV_W'(3);
    case (code)
      3'b000: begin d.src = SRC_XTAL; end
      3'b001: begin d.src = SRC_XTAL; d.co_en = 1'b1; d.co_div = DIV_W'(1); end
      3'b010: begin d.src = SRC_XTAL; d.co_en = 1'b1; d.co_div = DIV_W'(2); end
      3'b011: begin d.src = SRC_XTAL; d.co_en = 1'b1; d.co_div = DIV_W'(3); end
      3'b100: begin d.src = SRC_EXT; end
      3'b101: begin d.src = SRC_EXT; d.tick_div = DIV_W'(1); end
      3'b110: begin d.src = SRC_INT; d.tick_div = DIV_W'(1); end
      3'b111: begin
        d.src = SRC_INT; d.tick_div = DIV_W'(1);
        d.co_en = 1'b1; d.co_div = DIV_W'(1);
      end
      default: begin d.src = SRC_XTAL; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mdm_cfg_capture.sv
module mdm_cfg_capture #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] pins,
  output logic              pd,
  output logic [CODE_W-1:0] code_q
);

  // power-down flag: set at once by reset, cleared on the first edge after release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd <= 1'b1;
    else        pd <= 1'b0;
  end

  // code follows the pins while powered down, including the release edge
  always_ff @(posedge clk) begin
    if (pd) code_q <= pins;
  end

endmodule

// File: rtl/mdm_cdiv.sv
module mdm_cdiv #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             pulse
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt == (div - ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= (cnt == '0);
      cnt   <= wrap ? '0 : cnt + ONE;
    end
  end

endmodule

// File: rtl/mdm_clkout_gate.sv
module mdm_clkout_gate #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             pulse,
  output logic             clkout
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic is_div1;
  logic gate_lo;

  assign is_div1 = (div == ONE);

  // gate enable changes only while the clock is low, so the passed clock has no glitch
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_lo <= 1'b0;
    else        gate_lo <= ~pd & en & is_div1;
  end

  assign clkout = ~pd & (is_div1 ? (clk & gate_lo) : (pulse & en));

endmodule

// File: rtl/mdm_clkcfg.sv
module mdm_clkcfg
  import mdm_clkcfg_pkg::*;
(
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       xtal_en,
  input  logic       cfg0,
  input  logic       cfg1,
  output logic [1:0] src_sel,
  output logic       clkout_en,
  output logic       clkout,
  output logic       core_tick,
  output logic       pwr_down
);

  logic [CODE_W-1:0] code_q;
  cfg_dec_t          dec;
  logic [DIV_W-1:0]  tick_div;
  logic [DIV_W-1:0]  co_div;
  logic              co_run;
  logic              co_pulse;

  mdm_cfg_capture #(.CODE_W(CODE_W)) u_cap (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .pins   ({xtal_en, cfg1, cfg0}),
    .pd     (pwr_down),
    .code_q (code_q)
  );

  assign dec       = decode_code(code_q);
  assign src_sel   = dec.src;
  assign tick_div  = dec.tick_div;
  assign co_div    = dec.co_div;
  assign clkout_en = ~pwr_down & dec.co_en;
  assign co_run    = clkout_en & (co_div > DIV_W'(1));

  mdm_cdiv #(.DIV_W(DIV_W)) u_tick (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .run   (~pwr_down),
    .div   (tick_div),
    .pulse (core_tick)
  );

  mdm_cdiv #(.DIV_W(DIV_W)) u_codiv (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .run   (co_run),
    .div   (co_div),
    .pulse (co_pulse)
  );

  mdm_clkout_gate #(.DIV_W(DIV_W)) u_gate (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .pd     (pwr_down),
    .en     (clkout_en),
    .div    (co_div),
    .pulse  (co_pulse),
    .clkout (clkout)
  );

endmodule

// File: rtl/mdm_clkcfg_chk.sv
module mdm_clkcfg_chk #(
  parameter int DIV_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_down,
  input logic             core_tick,
  input logic             clkout_en,
  input logic [1:0]       src_sel,
  input logic [DIV_W-1:0] tick_div,
  input logic [DIV_W-1:0] co_div,
  input logic             co_pulse
);

  a_r1_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (!core_tick && !clkout_en));

  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && $past(!pwr_down)) |-> ($stable(src_sel) && $stable(tick_div) && $stable(co_div)));

  a_r4_no_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
    !clkout_en |-> !co_pulse);

  a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (core_tick && tick_div == DIV_W'(3)) |=> !core_tick);

  a_r5_tick_every: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_div == DIV_W'(1) && !pwr_down && $past(!pwr_down)) |-> core_tick);

  a_r7_div2_alt: assert property (@(posedge clk) disable iff (!rst_n)
    (co_div == DIV_W'(2) && co_pulse) |=> !co_pulse);

  a_r8_div3_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (co_div == DIV_W'(3) && co_pulse) |=> !co_pulse);

endmodule

bind mdm_clkcfg mdm_clkcfg_chk #(.DIV_W(mdm_clkcfg_pkg::DIV_W)) u_chk (
  .clk       (ref_clk),
  .rst_n     (rst_n),
  .pwr_down  (pwr_down),
  .core_tick (core_tick),
  .clkout_en (clkout_en),
  .src_sel   (src_sel),
  .tick_div  (tick_div),
  .co_div    (co_div),
  .co_pulse  (co_pulse)
);

// File: tb/mdm_clkcfg_tb_top.sv
`timescale 1ns/1ps
module mdm_clkcfg_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       xtal_en, cfg0, cfg1;
  logic [1:0] src_sel;
  logic       clkout_en, clkout, core_tick, pwr_down;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  mdm_clkcfg dut_i (
    .ref_clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .cfg0(cfg0), .cfg1(cfg1),
    .src_sel(src_sel), .clkout_en(clkout_en), .clkout(clkout),
    .core_tick(core_tick), .pwr_down(pwr_down)
  );

  // expected values from the requirements
  function automatic int exp_src(input logic [2:0] c);
    if (!c[2]) return 0;
    return c[1] ? 2 : 1;
  endfunction
  function automatic int exp_codiv(input logic [2:0] c);  // 0 means no clock output
    case (c)
      3'b001, 3'b111: return 1;
      3'b010:         return 2;
      3'b011:         return 3;
      default:        return 0;
    endcase
  endfunction
  function automatic int exp_tdiv(input logic [2:0] c);
    return (c == 3'b101 || c[2:1] == 2'b11) ? 1 : 3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_pins(input logic [2:0] c);
    xtal_en = c[2]; cfg1 = c[1]; cfg0 = c[0];
  endtask

  task automatic run_case(input logic [2:0] code, input int ncyc, input bit churn);
    int cd, td, es;
    cd = exp_codiv(code); td = exp_tdiv(code); es = exp_src(code);
    @(posedge clk); #15;
    rst_n = 1'b0;
    set_pins(code);
    #1;
    check(pwr_down == 1'b1, "R9 pwr_down on reset entry", pwr_down, 1);
    check(core_tick == 1'b0 && clkout == 1'b0, "R9 outputs quiet on reset entry",
          {core_tick, clkout}, 0);
    repeat (3) @(posedge clk);
    #5;
    check(pwr_down == 1'b1, "R1 pwr_down in reset", pwr_down, 1);
    check(core_tick == 1'b0 && clkout_en == 1'b0 && clkout == 1'b0, "R1 quiet in reset",
          {core_tick, clkout_en, clkout}, 0);
    #10;
    rst_n = 1'b1;
    @(posedge clk); #5;  // E0
    check(pwr_down == 1'b0, "R1 pwr_down after release", pwr_down, 0);
    check(int'(src_sel) == es, "R3 source select", src_sel, es);
    check(clkout_en == (cd != 0), "R4 clkout enable", clkout_en, int'(cd != 0));
    #10;
    if (churn) set_pins(3'($urandom));
    for (int k = 1; k <= ncyc; k++) begin
      int eh;
      @(posedge clk); #5;
      check(core_tick == (((k - 1) % td) == 0), "R5 core tick", core_tick,
            int'(((k - 1) % td) == 0));
      if (cd == 0)      begin eh = 0; check(clkout == 1'b0, "R4 clkout held low", clkout, eh); end
      else if (cd == 1) begin eh = 1; check(clkout == 1'b1, "R6 clkout high phase", clkout, eh); end
      else begin
        eh = int'(((k - 1) % cd) == 0);
        check(clkout == eh[0], (cd == 2) ? "R7 clkout div2" : "R8 clkout div3", clkout, eh);
      end
      if (churn) check(int'(src_sel) == es, "R2 source held after pin change", src_sel, es);
      #10;
      if (cd == 1)      check(clkout == 1'b0, "R6 clkout low phase", clkout, 0);
      else if (cd >= 2) check(clkout == eh[0], (cd == 2) ? "R7 clkout div2 low phase"
                                                          : "R8 clkout div3 low phase", clkout, eh);
      else              check(clkout == 1'b0, "R4 clkout low phase", clkout, 0);
      if (churn) set_pins(3'($urandom));
    end
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    set_pins(3'b000);
    repeat (2) @(posedge clk);
    // directed: every code, pins steady and then churned (R2)
    for (int c = 0; c < 8; c++) run_case(3'(c), 12, 1'b0);
    for (int c = 0; c < 8; c++) run_case(3'(c), 9, 1'b1);
    // random codes and run lengths
    for (int i = 0; i < 20; i++) run_case(3'($urandom), 4 + int'($urandom % 20), 1'($urandom));
    @(posedge clk); #15;
    rst_n = 1'b0;
    #1;
    check(pwr_down == 1'b1, "R9 final reset entry", pwr_down, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule